// File: doc/BRIEF.md
# Asynchronous Strobe-Handshake Bus Responder

This block is the responding end of a clockless backplane transfer. A requester puts an address on the bus, pulls an active-low address strobe, then pulls one or both active-low data strobes. On a write it also drives data. A direction line and an active-low long-word line complete the request. The responder samples the strobes into its own clock domain. It checks whether the address falls inside its window and works out the transfer width from the strobes, the long-word line and address bit 1. It then either stores the write data into a small word-wide register file, or places the addressed word on its read-data output and raises an output-enable. It answers with an active-low transfer acknowledge, or with an active-low bus error when the access is in its window but cannot be carried out.

A reply stays asserted until the requester has released both data strobes. The responder then withdraws it and waits for a fresh strobe fall before it takes the next transfer. Addresses outside the window get no reply at all, which leaves the bus to another responder. The output-enable is meant to drive an external tri-state buffer.

Top module: `strobe_slave`

## Requirements
- R1: While reset is high, and on the first cycle after it, dtack_n and berr_n are high and data_oe is low. This holds even when reset arrives in the middle of a reply.
- R2: A request whose address bits above the register-file index do not match the BASE parameter gets no reply: dtack_n and berr_n stay high and the register file is untouched. With the defaults the window is byte addresses 0x00A00000 to 0x00A0001F, holding eight 32-bit words indexed by address bits 4:2.
- R3: write_n low marks a write, and an accepted write updates only the byte lanes selected as follows. ds_n[1] low selects the upper byte and ds_n[0] low selects the lower byte of the 16-bit half chosen by address bit 1 (1 = bits 31:16, 0 = bits 15:0). With lword_n high, one strobe low gives an 8-bit access and both strobes low give a 16-bit access. With lword_n low, both strobes low and address bit 1 at 0 give a 32-bit access to all four lanes.
- R4: An accepted read (write_n high) of any supported width replies with acknowledge and presents the whole addressed 32-bit word on data_o.
- R5: A request in the window with lword_n low and address bit 1 at 1 is misaligned. It replies with bus error, leaves the register file unchanged and never raises data_oe.
- R6: A request in the window with lword_n low and only one data strobe low is an unsupported width. It replies with bus error and leaves the register file unchanged. dtack_n and berr_n are never low together.
- R7: On a read, data_oe is high in the cycle before dtack_n falls and remains high while acknowledge is held. On a write, data_oe stays low.
- R8: Acknowledge or bus error stays low for as long as either data strobe is low. Both are released, and data_oe is dropped on the same clock edge, once both strobes are seen high.
- R9: A data-strobe fall while the address strobe is high is ignored: no reply and no register-file change.
- R10: The width is decoded one clock after the first strobe fall is seen. A second strobe that falls up to one clock later still counts toward a 16-bit or 32-bit access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Responder clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W-1 | Byte address bits ADDR_W-1 down to 1 |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 2 | Data strobes, active low; [1] upper byte, [0] lower byte |
| lword_n | input | 1 | Long-word line, active low |
| write_n | input | 1 | Direction, low = write |
| data_i | input | 32 | Write data from the requester |
| data_o | output | 32 | Read data toward the bus buffer |
| data_oe | output | 1 | Enable for the read-data buffer |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| berr_n | output | 1 | Bus error, active low |

## Verification
A table of transfers combines long-word, half-word and single-byte writes on both halves and both byte strobes. Each write is followed by a full-word read, so a wrong lane mask shows up as a changed neighbour byte. Misaligned and unsupported-width requests are each followed by a read of the same word. This tells a correct error reply apart from an error reply that still wrote the data. Accesses just past the window check that the decode does not alias onto word 0. Directed cases skew the two strobes by one clock, drop the strobes while the address strobe is high, and reset the block in the middle of a held reply. The first case shows whether the width is decoded from the first strobe alone.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_DRIVE  = 2'd2,
    ST_RESP   = 2'd3
  } sb_state_e;
endpackage

// File: rtl/sb_sync.sv
module sb_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '1;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s - 1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sb_width_dec.sv
module sb_width_dec
  import sb_pkg::*;
(
  input  logic [1:0]       ds_n,
  input  logic             lword_n,
  input  logic             a1,
  output logic             any_strobe,
  output logic             bad,
  output logic [LANES-1:0] be
);
  logic hi, lo;
  assign hi = ~ds_n[1];
  assign lo = ~ds_n[0];
  assign any_strobe = hi | lo;

  always_comb begin
    be  = '0;
    bad = 1'b0;
    if (!lword_n) begin
      if (hi && lo && !a1) be = 4'b1111;
      else bad = 1'b1;
    end else begin
      be = a1 ? {hi, lo, 2'b00} : {2'b00, hi, lo};
    end
  end
endmodule

// File: rtl/sb_regfile.sv
module sb_regfile
  import sb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [IDX_W-1:0] waddr,
  input  logic [8*LANES-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [8*LANES-1:0] rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] rd_q;
    always_ff @(posedge clk) begin
      if (we && be[l]) mem[waddr] <= wdata[8*l +: 8];
      if (re) rd_q <= mem[raddr];
    end
    assign rdata[8*l +: 8] = rd_q;
  end
endmodule

// File: rtl/strobe_slave.sv
module strobe_slave
  import sb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 8,
  parameter logic [ADDR_W-1:0] BASE = 32'h00A0_0000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:1] addr_i,
  input  logic              as_n,
  input  logic [1:0]        ds_n,
  input  logic              lword_n,
  input  logic              write_n,
  input  logic [31:0]       data_i,
  output logic [31:0]       data_o,
  output logic              data_oe,
  output logic              dtack_n,
  output logic              berr_n
);
  localparam int unsigned IDX_W  = $clog2(DEPTH);
  localparam int unsigned TAG_LO = IDX_W + 2;

  logic       as_s;
  logic [1:0] ds_s, ds_prev;
  sb_state_e  st;

  sb_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({as_n, ds_n}), .q({as_s, ds_s})
  );

  logic             any_strobe, bad;
  logic [LANES-1:0] be;
  sb_width_dec u_dec (
    .ds_n(ds_s), .lword_n(lword_n), .a1(addr_i[1]),
    .any_strobe(any_strobe), .bad(bad), .be(be)
  );

  logic             hit, go, wr_en, rd_en;
  logic [IDX_W-1:0] idx;
  assign hit   = (addr_i[ADDR_W-1:TAG_LO] == BASE[ADDR_W-1:TAG_LO]);
  assign idx   = addr_i[TAG_LO-1:2];
  assign go    = (st == ST_SETTLE) && hit && !as_s && any_strobe;
  assign wr_en = go && !bad && !write_n;
  assign rd_en = go && !bad && write_n;

  sb_regfile #(.DEPTH(DEPTH)) u_rf (
    .clk(clk), .we(wr_en), .be(be), .waddr(idx), .wdata(data_i),
    .re(rd_en), .raddr(idx), .rdata(data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      ds_prev <= 2'b11;
      dtack_n <= 1'b1;
      berr_n  <= 1'b1;
      data_oe <= 1'b0;
    end else begin
      ds_prev <= ds_s;
      case (st)
        ST_IDLE: begin
          if (!as_s && ds_s != 2'b11 && ds_prev == 2'b11) st <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (!go) begin
            st <= ST_IDLE;
          end else if (bad) begin
            berr_n <= 1'b0;
            st     <= ST_RESP;
          end else if (!write_n) begin
            dtack_n <= 1'b0;
            st      <= ST_RESP;
          end else begin
            data_oe <= 1'b1;
            st      <= ST_DRIVE;
          end
        end
        ST_DRIVE: begin
          dtack_n <= 1'b0;
          st      <= ST_RESP;
        end
        ST_RESP: begin
          if (ds_s == 2'b11) begin
            dtack_n <= 1'b1;
            berr_n  <= 1'b1;
            data_oe <= 1'b0;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sb_checker.sv
module sb_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] ds_s,
  input logic       write_n,
  input logic       data_oe,
  input logic       dtack_n,
  input logic       berr_n
);
  logic was_rst = 1'b0;
  always_ff @(posedge clk) was_rst <= rst;

  always @(posedge clk) begin
    if (was_rst) begin
      AST_RESET_QUIET: assert (dtack_n && berr_n && !data_oe); // R1
    end
  end

  AST_ONE_REPLY: assert property (@(posedge clk) disable iff (rst)
    !(!dtack_n && !berr_n)); // R6

  AST_OE_LEADS_ACK: assert property (@(posedge clk) disable iff (rst)
    ($fell(dtack_n) && data_oe) |-> $past(data_oe)); // R7

  AST_WRITE_NO_OE: assert property (@(posedge clk) disable iff (rst)
    (!dtack_n && !write_n) |-> !data_oe); // R7

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!dtack_n && ds_s != 2'b11) |=> !dtack_n); // R8

  AST_BERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!berr_n && ds_s != 2'b11) |=> !berr_n); // R8

  AST_OE_DROP: assert property (@(posedge clk) disable iff (rst)
    $rose(dtack_n) |-> !data_oe); // R8
endmodule

bind strobe_slave sb_checker u_chk (
  .clk(clk), .rst(rst), .ds_s(ds_s), .write_n(write_n),
  .data_oe(data_oe), .dtack_n(dtack_n), .berr_n(berr_n)
);

// File: tb/strobe_slave_bench.sv
module strobe_slave_bench;
  localparam logic [31:0] BASE = 32'h00A0_0000;
  localparam int NONE = 0, ACK = 1, BERR = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:1] addr_i = '0;
  logic        as_n = 1'b1;
  logic [1:0]  ds_n = 2'b11;
  logic        lword_n = 1'b1;
  logic        write_n = 1'b1;
  logic [31:0] data_i = '0;
  logic [31:0] data_o;
  logic        data_oe, dtack_n, berr_n;

  always #5 clk = ~clk;

  strobe_slave u_strobe_slave (
    .clk(clk), .rst(rst), .addr_i(addr_i), .as_n(as_n), .ds_n(ds_n),
    .lword_n(lword_n), .write_n(write_n), .data_i(data_i), .data_o(data_o),
    .data_oe(data_oe), .dtack_n(dtack_n), .berr_n(berr_n)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [1:0]  ds;
    logic        lw_n;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [1:0]  resp;
    logic [31:0] rdata;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b00, 1'b0, BASE + 32'h00, 32'h1122_3344, 2'd1, 32'h0, 8'd3},  // R3 long
    '{1'b0, 2'b00, 1'b0, BASE + 32'h00, 32'h0,         2'd1, 32'h1122_3344, 8'd4}, // R4
    '{1'b1, 2'b01, 1'b1, BASE + 32'h00, 32'hAAAA_AAAA, 2'd1, 32'h0, 8'd3},  // R3 upper byte, low half
    '{1'b0, 2'b00, 1'b0, BASE + 32'h00, 32'h0,         2'd1, 32'h1122_AA44, 8'd3},
    '{1'b1, 2'b10, 1'b1, BASE + 32'h02, 32'h5555_5555, 2'd1, 32'h0, 8'd3},  // R3 lower byte, high half
    '{1'b0, 2'b00, 1'b0, BASE + 32'h00, 32'h0,         2'd1, 32'h1155_AA44, 8'd3},
    '{1'b1, 2'b00, 1'b0, BASE + 32'h04, 32'hCAFE_F00D, 2'd1, 32'h0, 8'd3},
    '{1'b1, 2'b00, 1'b1, BASE + 32'h06, 32'hBEEF_1234, 2'd1, 32'h0, 8'd3},  // R3 half, high
    '{1'b0, 2'b00, 1'b0, BASE + 32'h04, 32'h0,         2'd1, 32'hBEEF_F00D, 8'd3},
    '{1'b1, 2'b00, 1'b0, BASE + 32'h06, 32'h0,         2'd2, 32'h0, 8'd5},  // R5 misaligned write
    '{1'b0, 2'b00, 1'b0, BASE + 32'h04, 32'h0,         2'd1, 32'hBEEF_F00D, 8'd5},
    '{1'b0, 2'b00, 1'b0, BASE + 32'h06, 32'h0,         2'd2, 32'h0, 8'd5},  // R5 misaligned read
    '{1'b1, 2'b01, 1'b0, BASE + 32'h00, 32'h0,         2'd2, 32'h0, 8'd6},  // R6 byte with lword
    '{1'b0, 2'b00, 1'b0, BASE + 32'h00, 32'h0,         2'd1, 32'h1155_AA44, 8'd6},
    '{1'b0, 2'b01, 1'b1, BASE + 32'h06, 32'h0,         2'd1, 32'hBEEF_F00D, 8'd4}, // R4 byte read
    '{1'b1, 2'b00, 1'b0, BASE + 32'h1C, 32'h0BAD_BEEF, 2'd1, 32'h0, 8'd3},
    '{1'b0, 2'b00, 1'b0, BASE + 32'h1C, 32'h0,         2'd1, 32'h0BAD_BEEF, 8'd4},
    '{1'b1, 2'b00, 1'b0, BASE + 32'h20, 32'hDEAD_0000, 2'd0, 32'h0, 8'd2},  // R2 past window
    '{1'b0, 2'b00, 1'b0, BASE - 32'h04, 32'h0,         2'd0, 32'h0, 8'd2},  // R2 below window
    '{1'b0, 2'b00, 1'b0, BASE + 32'h00, 32'h0,         2'd1, 32'h1155_AA44, 8'd2}
  };

  task automatic xfer(input logic wr, input logic [1:0] ds, input logic lw_n,
                      input logic [31:0] addr, input logic [31:0] wdata, input bit skew,
                      input string req, output int resp, output logic [31:0] rdata);
    bit prev_oe, prev_ack, oe_ok, hold_ok, write_oe;
    resp = NONE; rdata = '0; oe_ok = 1'b1; hold_ok = 1'b1; write_oe = 1'b0;
    @(negedge clk);
    addr_i = addr[31:1]; write_n = ~wr; lword_n = lw_n; data_i = wdata;
    @(negedge clk);
    as_n = 1'b0;
    @(negedge clk);
    if (skew) begin
      ds_n = {ds[1], 1'b1};
      @(negedge clk);
    end
    ds_n = ds;
    prev_oe = data_oe; prev_ack = dtack_n;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (wr && data_oe) write_oe = 1'b1;
      if (!dtack_n || !berr_n) begin
        resp = !dtack_n ? ACK : BERR;
        if (!wr && !dtack_n) oe_ok = prev_oe && prev_ack && data_oe;
        break;
      end
      prev_oe = data_oe; prev_ack = dtack_n;
    end
    if (resp == BERR) chk(!data_oe && !prev_oe, {req, " oe during error"}, {31'd0, data_oe}, 32'd0);
    if (resp == ACK && !wr) begin
      chk(oe_ok, "R7 oe one cycle before ack", {31'd0, oe_ok}, 32'd1);
      rdata = data_o;
    end
    if (wr) chk(!write_oe, "R7 no oe on write", {31'd0, write_oe}, 32'd0);
    if (resp != NONE) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if ((resp == ACK && dtack_n) || (resp == BERR && berr_n)) hold_ok = 1'b0;
      end
      chk(hold_ok, "R8 reply held while strobes low", {31'd0, hold_ok}, 32'd1);
    end
    ds_n = 2'b11; as_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (dtack_n && berr_n) break;
    end
    if (resp != NONE)
      chk(dtack_n && berr_n && !data_oe, "R8 release and oe drop",
          {29'd0, dtack_n, berr_n, data_oe}, 32'b110);
    @(negedge clk);
  endtask

  initial begin
    int resp;
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    chk(dtack_n && berr_n && !data_oe, "R1 reset outputs", {29'd0, dtack_n, berr_n, data_oe}, 32'b110);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
      xfer(VECS[v].wr, VECS[v].ds, VECS[v].lw_n, VECS[v].addr, VECS[v].wdata, 1'b0, tag, resp, rd);
      chk(resp == int'(VECS[v].resp), {tag, " reply"}, resp, VECS[v].resp);
      if (!VECS[v].wr && VECS[v].resp == 2'd1)
        chk(rd == VECS[v].rdata, {tag, " data"}, rd, VECS[v].rdata);
    end

    // R10: skewed strobes must still yield a 16-bit write
    xfer(1'b1, 2'b00, 1'b0, BASE + 32'h08, 32'hFFFF_0000, 1'b0, "R10 setup", resp, rd);
    xfer(1'b1, 2'b00, 1'b1, BASE + 32'h08, 32'h1234_5678, 1'b1, "R10 skew", resp, rd);
    chk(resp == ACK, "R10 skew reply", resp, ACK);
    xfer(1'b0, 2'b00, 1'b0, BASE + 32'h08, 32'h0, 1'b0, "R10 read", resp, rd);
    chk(rd == 32'hFFFF_5678, "R10 skewed half write", rd, 32'hFFFF_5678);

    // R9: data strobes fall while address strobe is high
    @(negedge clk);
    addr_i = BASE[31:1] + 31'h4; write_n = 1'b0; lword_n = 1'b0; data_i = 32'h0;
    @(negedge clk);
    ds_n = 2'b00;
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (!dtack_n || !berr_n) quiet = 1'b0;
      end
      chk(quiet, "R9 no reply without address strobe", {31'd0, quiet}, 32'd1);
    end
    ds_n = 2'b11;
    repeat (4) @(negedge clk);
    xfer(1'b0, 2'b00, 1'b0, BASE + 32'h08, 32'h0, 1'b0, "R9 read", resp, rd);
    chk(rd == 32'hFFFF_5678, "R9 word untouched", rd, 32'hFFFF_5678);

    // R1: reset during a held acknowledge
    @(negedge clk);
    addr_i = BASE[31:1]; write_n = 1'b1; lword_n = 1'b0;
    @(negedge clk); as_n = 1'b0;
    @(negedge clk); ds_n = 2'b00;
    repeat (8) @(negedge clk);
    chk(!dtack_n, "R1 ack before reset", {31'd0, dtack_n}, 32'd0);
    rst = 1'b1;
    @(negedge clk);
    chk(dtack_n && berr_n && !data_oe, "R1 reset mid reply", {29'd0, dtack_n, berr_n, data_oe}, 32'b110);
    rst = 1'b0;
    @(negedge clk);
    chk(dtack_n && berr_n && !data_oe, "R1 after reset", {29'd0, dtack_n, berr_n, data_oe}, 32'b110);
    ds_n = 2'b11; as_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule